// File: doc/BRIEF.md
# Label-Mapping TLV Loop Checker

This block inspects one label-mapping message at a time, presented as a stream of octets, and decides whether the message may be re-advertised upstream. The message is a sequence of TLVs placed back to back. The block decodes each TLV header as it arrives. It applies the rules for TLV types it does not recognise. It tracks a hop-count TLV and a path-vector TLV of router IDs. It detects whether the path vector already holds the local router ID.

One cycle after the last octet of the message, the block produces a decision: accept, reject or notify. With an accept it also gives three results. The first is the hop count to advertise, which is the received count plus one. The second is a flag telling whether an unknown TLV must travel on with the message. The third is the length of the outgoing path vector, which is the received list with the local router ID appended. The outgoing vector is read one entry at a time through an index port. The read is valid from the decision until the first octet of the next message.

Top module: `ldp_loop_chk`

## Requirements
- R1: Each TLV header is four octets. In octet 0, bit 7 is U and bit 6 is F. Octet 0 bits 5:0 followed by octet 1 form the 14-bit type. Octets 2 and 3 form the value length, most significant octet first. The value octets follow the header, and the next TLV starts straight after them.
- R2: A TLV whose type is neither 0x0103 (hop count) nor 0x0104 (path vector) and whose U is 1 is skipped without affecting the decision. If F is also 1, `fwd_o` is 1 with an accept.
- R3: An unknown TLV with U equal to 0 gives decision code 2 (notify). Notify takes priority over any cause of rejection in the same message.
- R4: The hop-count TLV carries one value octet h. On accept, `hop_vld_o` is 1 and `hop_o` is h+1. When the message carries no hop-count TLV, `hop_vld_o` and `hop_o` are 0.
- R5: The message is rejected (code 1) when h+1 exceeds `max_hop_i`, or when the hop-count TLV length is not 1.
- R6: Any path-vector entry equal to `local_id_i` rejects the message. Each entry is 4 octets, most significant octet first.
- R7: On accept, `pv_cnt_o` is n+1, where n is the number of received entries. Reading index k < n returns the k-th received entry in arrival order, and index n returns `local_id_i`.
- R8: The message is rejected when a path-vector length is not a multiple of 4, when a single vector exceeds 64 octets, or when the message carries more than 16 entries in total.
- R9: A message whose last octet does not complete a TLV (header or value) is rejected.
- R10: `dec_valid_o` is high for exactly the one cycle after the cycle that carries the last octet, with code 0 for accept. With a reject or notify decision, `pv_cnt_o`, `hop_vld_o` and `fwd_o` are 0.
- R11: While reset is held, `dec_valid_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Octet present |
| in_data_i | input | 8 | Message octet |
| in_last_i | input | 1 | Octet is the final one of the message |
| local_id_i | input | ID_W | Router ID of this node |
| max_hop_i | input | 8 | Largest hop count allowed to go out |
| rd_idx_i | input | CNT_W | Outgoing path-vector read index |
| rd_data_o | output | ID_W | Outgoing path-vector entry at `rd_idx_i` |
| dec_valid_o | output | 1 | Decision strobe |
| dec_o | output | 2 | 0 accept, 1 reject, 2 notify |
| hop_vld_o | output | 1 | Hop count present in an accepted message |
| hop_o | output | 8 | Hop count to advertise |
| pv_cnt_o | output | CNT_W | Outgoing path-vector entry count |
| fwd_o | output | 1 | Unknown TLV to be forwarded |

## Verification
The bench aims at the edges of the hop limit. One case leaves the incremented count exactly at the maximum, another one past it, and another uses a received count of 255. A design that compares with the wrong inequality, or that lets the 8-bit count wrap, accepts a looping message. Further cases put the local ID at the start, middle and end of the path vector, and use vectors of exactly 16 and 17 entries, including 17 spread over two TLVs. These catch a design that misses the last word of a vector or that caps only one TLV. Other cases cut messages short inside a header and inside a value, mix a notify cause with a reject cause, and use a 256-octet unknown TLV. These expose a lost resynchronisation, a wrong priority and a length that ignores its high octet. Back-to-back messages with no idle cycle check that the state of one message does not leak into the next.

// File: rtl/ldp_chk_pkg.sv
package ldp_chk_pkg;
  typedef enum logic [1:0] {
    DEC_ACCEPT = 2'd0,
    DEC_REJECT = 2'd1,
    DEC_NOTIFY = 2'd2
  } dec_e;

  typedef enum logic {
    PS_HDR = 1'b0,
    PS_VAL = 1'b1
  } pstate_e;

  typedef struct packed {
    logic        u;
    logic        f;
    logic [13:0] typ;
    logic [15:0] len;
  } tlv_hdr_t;
endpackage

// File: rtl/ldp_tlv_parser.sv
module ldp_tlv_parser
  import ldp_chk_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        beat_i,
  input  logic        last_i,
  input  logic [7:0]  byte_i,
  output logic        hdr_fire_o,
  output tlv_hdr_t    hdr_o,
  output logic [13:0] cur_typ_o,
  output logic        val_beat_o,
  output logic        tlv_end_o
);
  pstate_e     st_q;
  logic [1:0]  hidx_q;
  logic [23:0] hpart_q;
  logic [13:0] cur_typ_q;
  logic [15:0] rem_q;

  always_comb begin
    hdr_o.u   = hpart_q[23];
    hdr_o.f   = hpart_q[22];
    hdr_o.typ = hpart_q[21:8];
    hdr_o.len = {hpart_q[7:0], byte_i};
  end

  assign hdr_fire_o = beat_i && (st_q == PS_HDR) && (hidx_q == 2'd3);
  assign val_beat_o = beat_i && (st_q == PS_VAL);
  assign tlv_end_o  = (hdr_fire_o && (hdr_o.len == 16'd0)) ||
                      (val_beat_o && (rem_q == 16'd1));
  assign cur_typ_o  = cur_typ_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= PS_HDR;
      hidx_q    <= '0;
      hpart_q   <= '0;
      cur_typ_q <= '0;
      rem_q     <= '0;
    end else if (beat_i) begin
      if (last_i) begin
        // resync for the next message whatever the framing
        st_q   <= PS_HDR;
        hidx_q <= '0;
      end else if (st_q == PS_HDR) begin
        hpart_q <= {hpart_q[15:0], byte_i};
        hidx_q  <= hidx_q + 2'd1;
        if (hidx_q == 2'd3) begin
          cur_typ_q <= hdr_o.typ;
          if (hdr_o.len != 16'd0) begin
            st_q  <= PS_VAL;
            rem_q <= hdr_o.len;
          end
        end
      end else begin
        rem_q <= rem_q - 16'd1;
        if (rem_q == 16'd1) st_q <= PS_HDR;
      end
    end
  end
endmodule

// File: rtl/ldp_hop_unit.sv
module ldp_hop_unit (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       sop_i,
  input  logic       sel_i,
  input  logic [7:0] byte_i,
  output logic       seen_o,
  output logic [8:0] inc_o
);
  logic       seen_q;
  logic [7:0] hop_q;
  logic [7:0] hop_n;

  always_comb begin
    seen_o = sel_i || (!sop_i && seen_q);
    hop_n  = sel_i ? byte_i : (sop_i ? 8'd0 : hop_q);
    inc_o  = {1'b0, hop_n} + 9'd1;  // 9 bits: 255 must not wrap
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seen_q <= 1'b0;
      hop_q  <= '0;
    end else begin
      seen_q <= seen_o;
      hop_q  <= hop_n;
    end
  end
endmodule

// File: rtl/ldp_pv_unit.sv
module ldp_pv_unit #(
  parameter int unsigned ID_W   = 32,
  parameter int unsigned PV_MAX = 16,
  parameter int unsigned CNT_W  = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sop_i,
  input  logic             sel_i,
  input  logic [7:0]       byte_i,
  input  logic [ID_W-1:0]  local_id_i,
  input  logic [CNT_W-1:0] rd_idx_i,
  output logic             hit_o,
  output logic             ovf_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic [ID_W-1:0]  rd_data_o
);
  localparam int unsigned BPW  = ID_W / 8;
  localparam int unsigned BI_W = (BPW > 1) ? $clog2(BPW) : 1;
  localparam int unsigned IW   = (PV_MAX > 1) ? $clog2(PV_MAX) : 1;

  logic [ID_W-9:0]              sh_q;
  logic [BI_W-1:0]              bidx_q;
  logic [CNT_W-1:0]             cnt_q;
  logic [CNT_W-1:0]             cnt_base;
  logic [ID_W-1:0]              word;
  logic                         word_fire;
  logic                         wr_en;
  logic [PV_MAX-1:0][ID_W-1:0]  ent;

  assign word      = {sh_q, byte_i};
  assign word_fire = sel_i && (bidx_q == BI_W'(BPW - 1));
  assign cnt_base  = sop_i ? '0 : cnt_q;
  assign hit_o     = word_fire && (word == local_id_i);
  assign ovf_o     = word_fire && (cnt_base == CNT_W'(PV_MAX));
  assign wr_en     = word_fire && !ovf_o;
  assign cnt_o     = wr_en ? cnt_base + CNT_W'(1) : cnt_base;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q   <= '0;
      bidx_q <= '0;
      cnt_q  <= '0;
    end else begin
      cnt_q <= cnt_o;
      if (sop_i) bidx_q <= '0;
      else if (sel_i) begin
        sh_q   <= word[ID_W-9:0];
        bidx_q <= word_fire ? '0 : bidx_q + BI_W'(1);
      end
    end
  end

  for (genvar g = 0; g < PV_MAX; g++) begin : g_ent
    logic [ID_W-1:0] ent_q;
    always_ff @(posedge clk_i) begin
      if (wr_en && (cnt_base == CNT_W'(g))) ent_q <= word;
    end
    assign ent[g] = ent_q;
  end

  always_comb begin
    if (rd_idx_i == cnt_q)     rd_data_o = local_id_i;
    else if (rd_idx_i < cnt_q) rd_data_o = ent[rd_idx_i[IW-1:0]];
    else                       rd_data_o = '0;
  end
endmodule

// File: rtl/ldp_loop_chk.sv
module ldp_loop_chk
  import ldp_chk_pkg::*;
#(
  parameter int unsigned ID_W     = 32,
  parameter int unsigned PV_MAX   = 16,
  parameter logic [13:0] HOP_TYPE = 14'h0103,
  parameter logic [13:0] PV_TYPE  = 14'h0104,
  localparam int unsigned CNT_W   = $clog2(PV_MAX + 2)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             in_valid_i,
  input  logic [7:0]       in_data_i,
  input  logic             in_last_i,
  input  logic [ID_W-1:0]  local_id_i,
  input  logic [7:0]       max_hop_i,
  input  logic [CNT_W-1:0] rd_idx_i,
  output logic [ID_W-1:0]  rd_data_o,
  output logic             dec_valid_o,
  output logic [1:0]       dec_o,
  output logic             hop_vld_o,
  output logic [7:0]       hop_o,
  output logic [CNT_W-1:0] pv_cnt_o,
  output logic             fwd_o
);
  localparam int unsigned BPW = ID_W / 8;

  logic             mid_q, sop, end_beat;
  tlv_hdr_t         hdr;
  logic [13:0]      cur_typ;
  logic             hdr_fire, val_beat, tlv_end;
  logic             hop_sel, pv_sel, hop_seen;
  logic [8:0]       hop_inc;
  logic             pv_hit, pv_ovf;
  logic [CNT_W-1:0] pv_cnt;
  logic             rej_q, ntf_q, fwd_q, rej_n, ntf_n, fwd_n;
  logic             hdr_hop, hdr_pv;
  dec_e             dec_n, dec_q;
  logic             dvld_q, hvld_q, fwdo_q;
  logic [7:0]       hop_q;
  logic [CNT_W-1:0] cnt_q;

  assign sop      = in_valid_i && !mid_q;
  assign end_beat = in_valid_i && in_last_i;
  assign hop_sel  = val_beat && (cur_typ == HOP_TYPE);
  assign pv_sel   = val_beat && (cur_typ == PV_TYPE);
  assign hdr_hop  = hdr.typ == HOP_TYPE;
  assign hdr_pv   = hdr.typ == PV_TYPE;

  ldp_tlv_parser u_parser (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .beat_i     (in_valid_i),
    .last_i     (in_last_i),
    .byte_i     (in_data_i),
    .hdr_fire_o (hdr_fire),
    .hdr_o      (hdr),
    .cur_typ_o  (cur_typ),
    .val_beat_o (val_beat),
    .tlv_end_o  (tlv_end)
  );

  ldp_hop_unit u_hop (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sop_i  (sop),
    .sel_i  (hop_sel),
    .byte_i (in_data_i),
    .seen_o (hop_seen),
    .inc_o  (hop_inc)
  );

  ldp_pv_unit #(.ID_W(ID_W), .PV_MAX(PV_MAX), .CNT_W(CNT_W)) u_pv (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sop_i      (sop),
    .sel_i      (pv_sel),
    .byte_i     (in_data_i),
    .local_id_i (local_id_i),
    .rd_idx_i   (rd_idx_i),
    .hit_o      (pv_hit),
    .ovf_o      (pv_ovf),
    .cnt_o      (pv_cnt),
    .rd_data_o  (rd_data_o)
  );

  always_comb begin
    rej_n = sop ? 1'b0 : rej_q;
    ntf_n = sop ? 1'b0 : ntf_q;
    fwd_n = sop ? 1'b0 : fwd_q;
    if (hdr_fire) begin
      if (hdr_hop) begin
        if (hdr.len != 16'd1) rej_n = 1'b1;
      end else if (hdr_pv) begin
        if ((hdr.len % 16'(BPW)) != 16'd0 || hdr.len > 16'(BPW * PV_MAX)) rej_n = 1'b1;
      end else if (!hdr.u) begin
        ntf_n = 1'b1;
      end else if (hdr.f) begin
        fwd_n = 1'b1;
      end
    end
    if (pv_hit || pv_ovf) rej_n = 1'b1;
    if (end_beat) begin
      if (!tlv_end) rej_n = 1'b1;
      if (hop_seen && (hop_inc > {1'b0, max_hop_i})) rej_n = 1'b1;
    end
    dec_n = ntf_n ? DEC_NOTIFY : (rej_n ? DEC_REJECT : DEC_ACCEPT);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mid_q  <= 1'b0;
      rej_q  <= 1'b0;
      ntf_q  <= 1'b0;
      fwd_q  <= 1'b0;
      dvld_q <= 1'b0;
      dec_q  <= DEC_ACCEPT;
      hvld_q <= 1'b0;
      hop_q  <= '0;
      cnt_q  <= '0;
      fwdo_q <= 1'b0;
    end else begin
      dvld_q <= end_beat;
      if (in_valid_i) begin
        mid_q <= !in_last_i;
        rej_q <= rej_n;
        ntf_q <= ntf_n;
        fwd_q <= fwd_n;
      end
      if (end_beat) begin
        dec_q  <= dec_n;
        hvld_q <= (dec_n == DEC_ACCEPT) && hop_seen;
        hop_q  <= ((dec_n == DEC_ACCEPT) && hop_seen) ? hop_inc[7:0] : 8'd0;
        cnt_q  <= (dec_n == DEC_ACCEPT) ? pv_cnt + CNT_W'(1) : '0;
        fwdo_q <= (dec_n == DEC_ACCEPT) && fwd_n;
      end
    end
  end

  assign dec_valid_o = dvld_q;
  assign dec_o       = dec_q;
  assign hop_vld_o   = hvld_q;
  assign hop_o       = hop_q;
  assign pv_cnt_o    = cnt_q;
  assign fwd_o       = fwdo_q;
endmodule

// File: rtl/ldp_loop_chk_sva.sv
module ldp_loop_chk_sva #(
  parameter int unsigned ID_W   = 32,
  parameter int unsigned PV_MAX = 16,
  localparam int unsigned CNT_W = $clog2(PV_MAX + 2)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             in_valid_i,
  input logic             in_last_i,
  input logic [ID_W-1:0]  local_id_i,
  input logic [7:0]       max_hop_i,
  input logic [CNT_W-1:0] rd_idx_i,
  input logic [ID_W-1:0]  rd_data_o,
  input logic             dec_valid_o,
  input logic [1:0]       dec_o,
  input logic             hop_vld_o,
  input logic [7:0]       hop_o,
  input logic [CNT_W-1:0] pv_cnt_o,
  input logic             fwd_o
);
  p_dec_after_last_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && in_last_i) |=> dec_valid_o);

  p_dec_has_cause_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dec_valid_o |-> $past(in_valid_i && in_last_i));

  p_dec_code_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dec_valid_o |-> (dec_o != 2'd3));

  p_acc_cnt_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dec_valid_o && dec_o == 2'd0) |-> (pv_cnt_o != '0 && pv_cnt_o <= CNT_W'(PV_MAX + 1)));

  p_nonacc_clear_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dec_valid_o && dec_o != 2'd0) |-> (pv_cnt_o == '0 && !hop_vld_o && !fwd_o));

  p_hop_limit_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dec_valid_o && hop_vld_o) |-> (hop_o <= max_hop_i && hop_o != 8'd0));

  p_tail_is_self_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dec_valid_o && dec_o == 2'd0 && rd_idx_i == pv_cnt_o - CNT_W'(1)) |-> (rd_data_o == local_id_i));
endmodule

bind ldp_loop_chk ldp_loop_chk_sva #(.ID_W(ID_W), .PV_MAX(PV_MAX)) u_sva (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .in_valid_i  (in_valid_i),
  .in_last_i   (in_last_i),
  .local_id_i  (local_id_i),
  .max_hop_i   (max_hop_i),
  .rd_idx_i    (rd_idx_i),
  .rd_data_o   (rd_data_o),
  .dec_valid_o (dec_valid_o),
  .dec_o       (dec_o),
  .hop_vld_o   (hop_vld_o),
  .hop_o       (hop_o),
  .pv_cnt_o    (pv_cnt_o),
  .fwd_o       (fwd_o)
);

// File: tb/ldp_loop_chk_tb_top.sv
module ldp_loop_chk_tb_top;
  localparam int HOP_T = 'h0103;
  localparam int PV_T  = 'h0104;
  localparam int UNK_T = 'h3F00;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [7:0]  in_data = '0;
  logic        in_last = 1'b0;
  logic [31:0] local_id = 32'h0A00_0005;
  logic [7:0]  max_hop = 8'd32;
  logic [4:0]  rd_idx = '0;
  logic [31:0] rd_data;
  logic        dec_valid;
  logic [1:0]  dec;
  logic        hop_vld;
  logic [7:0]  hop;
  logic [4:0]  pv_cnt;
  logic        fwd;

  always #5 clk = ~clk;

  ldp_loop_chk dut_i (
    .clk_i(clk), .rst_ni(rst_n), .in_valid_i(in_valid), .in_data_i(in_data),
    .in_last_i(in_last), .local_id_i(local_id), .max_hop_i(max_hop),
    .rd_idx_i(rd_idx), .rd_data_o(rd_data), .dec_valid_o(dec_valid),
    .dec_o(dec), .hop_vld_o(hop_vld), .hop_o(hop), .pv_cnt_o(pv_cnt), .fwd_o(fwd)
  );

  typedef struct {
    logic [1:0] dec;
    logic       hv;
    logic [7:0] hop;
    logic [4:0] cnt;
    logic       fwd;
    string      req;
  } exp_t;

  exp_t        exp_q[$];
  logic [7:0]  msg[$];
  logic [31:0] ids[$];
  int nchk = 0;
  int nfail = 0;

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] expv);
    nchk++;
    if (act !== expv) begin
      nfail++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, act, expv);
    end
  endtask

  task automatic put_hdr(bit u, bit f, int typ, int len);
    msg.push_back({u, f, typ[13:8]});
    msg.push_back(typ[7:0]);
    msg.push_back(len[15:8]);
    msg.push_back(len[7:0]);
  endtask

  task automatic put_hop(int v);
    put_hdr(0, 0, HOP_T, 1);
    msg.push_back(v[7:0]);
  endtask

  task automatic put_pv(int n, int self_at);
    put_hdr(0, 0, PV_T, 4 * n);
    for (int k = 0; k < n; k++) begin
      logic [31:0] id;
      id = (k == self_at) ? local_id : 32'hC0A8_0100 + 32'(k * 7 + 1);
      msg.push_back(id[31:24]); msg.push_back(id[23:16]);
      msg.push_back(id[15:8]);  msg.push_back(id[7:0]);
    end
  endtask

  task automatic put_unk(bit u, bit f, int len);
    put_hdr(u, f, UNK_T, len);
    for (int k = 0; k < len; k++) msg.push_back(8'(k));
  endtask

  // reference model written from the requirements
  task automatic model(output exp_t e);
    int i, len, typ, hv;
    bit u, f, rej, ntf, fw, hs, acc;
    i = 0; rej = 0; ntf = 0; fw = 0; hs = 0; hv = 0;
    ids.delete();
    while (i < msg.size()) begin
      if (msg.size() - i < 4) begin rej = 1; break; end
      u = msg[i][7]; f = msg[i][6];
      typ = {18'd0, msg[i][5:0], msg[i+1]};
      len = {16'd0, msg[i+2], msg[i+3]};
      i += 4;
      if (typ == HOP_T) begin
        if (len != 1) rej = 1;
      end else if (typ == PV_T) begin
        if (len % 4 != 0 || len > 64) rej = 1;
      end else if (!u) ntf = 1;
      else if (f) fw = 1;
      if (msg.size() - i < len) begin rej = 1; break; end
      if (typ == HOP_T && len > 0) begin hs = 1; hv = int'(msg[i+len-1]); end
      if (typ == PV_T) begin
        for (int w = 0; w + 4 <= len; w += 4) begin
          logic [31:0] id;
          id = {msg[i+w], msg[i+w+1], msg[i+w+2], msg[i+w+3]};
          if (id == local_id) rej = 1;
          if (ids.size() == 16) rej = 1;
          else ids.push_back(id);
        end
      end
      i += len;
    end
    if (hs && hv + 1 > int'(max_hop)) rej = 1;
    acc   = !ntf && !rej;
    e.dec = ntf ? 2'd2 : (rej ? 2'd1 : 2'd0);
    e.hv  = acc && hs;
    e.hop = (acc && hs) ? 8'(hv + 1) : 8'd0;
    e.cnt = acc ? 5'(ids.size() + 1) : 5'd0;
    e.fwd = acc && fw;
  endtask

  task automatic send(string req, bit rb, bit gap = 1);
    exp_t e;
    model(e);
    e.req = req;
    exp_q.push_back(e);
    foreach (msg[k]) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_data  = msg[k];
      in_last  = (k == msg.size() - 1);
    end
    if (gap) begin
      @(negedge clk);
      in_valid = 1'b0;
      in_last  = 1'b0;
      if (rb && e.dec == 2'd0) begin
        for (int k = 0; k <= ids.size(); k++) begin
          rd_idx = 5'(k);
          #1;
          chk(req, "pv entry", rd_data, (k == ids.size()) ? local_id : ids[k]);
        end
      end
    end
    msg.delete();
  endtask

  // scoreboard monitor
  logic last_seen = 1'b0;
  always @(posedge clk) last_seen <= in_valid && in_last;

  always @(negedge clk) begin : mon
    exp_t e;
    if (rst_n) begin
      if (dec_valid || last_seen) chk("R10", "decision timing", 32'(dec_valid), 32'(last_seen));
      if (dec_valid) begin
        if (exp_q.size() == 0) chk("R10", "unexpected decision", 32'(1), 32'(0));
        else begin
          e = exp_q.pop_front();
          chk(e.req, "decision", 32'(dec), 32'(e.dec));
          chk(e.req, "hop valid", 32'(hop_vld), 32'(e.hv));
          chk(e.req, "hop", 32'(hop), 32'(e.hop));
          chk(e.req, "pv count", 32'(pv_cnt), 32'(e.cnt));
          chk(e.req, "forward", 32'(fwd), 32'(e.fwd));
        end
      end
    end
  end

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog: got hung expected done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R11", "valid in reset", 32'(dec_valid), 32'(0));
    rst_n = 1'b1;
    @(negedge clk);

    // R1 R4 R7 basic accept
    put_hop(1); put_pv(1, -1); send("R1 R4 R7 basic", 1);
    put_pv(3, -1); put_hop(7); send("R4 R7 order", 1);
    // R6 self id at start, middle, end
    put_hop(2); put_pv(4, 0); send("R6 self first", 1);
    put_hop(2); put_pv(5, 2); send("R6 self middle", 1);
    put_pv(6, 5); send("R6 self last", 1);
    // R2 unknown U=1
    put_hop(3); put_unk(1, 1, 3); put_pv(2, -1); send("R2 fwd", 1);
    put_unk(1, 0, 2); put_hop(3); send("R2 skip", 1);
    put_unk(1, 0, 0); put_unk(1, 1, 256); send("R1 R2 long len", 1);
    // R3 notify, dominating reject
    put_hop(1); put_unk(0, 1, 2); send("R3 notify", 1);
    put_pv(2, 1); put_unk(0, 0, 1); put_hop(40); send("R3 priority", 1);
    // R5 hop limits
    max_hop = 8'd5;
    put_hop(4); send("R5 at max", 1);
    put_hop(5); send("R5 over max", 1);
    max_hop = 8'd255;
    put_hop(254); send("R5 top", 1);
    put_hop(255); send("R5 wrap", 1);
    max_hop = 8'd32;
    put_hdr(0, 0, HOP_T, 2); msg.push_back(8'd1); msg.push_back(8'd1); send("R5 hop len", 1);
    // R8 vector sizes
    put_pv(16, -1); send("R7 R8 sixteen", 1);
    put_pv(17, -1); send("R8 seventeen", 1);
    put_pv(10, -1); put_pv(7, -1); send("R8 split", 1);
    put_pv(9, -1); put_pv(7, -1); send("R7 R8 split ok", 1);
    put_hdr(0, 0, PV_T, 6); for (int k = 0; k < 6; k++) msg.push_back(8'(k)); send("R8 misaligned", 1);
    // R9 truncation
    put_hop(1); msg.push_back(8'h01); msg.push_back(8'h04); send("R9 cut header", 1);
    put_hop(1); put_pv(2, -1); void'(msg.pop_back()); send("R9 cut value", 1);
    put_hop(1); send("R9 resync", 1);
    // R4 no hop TLV, R10 back to back
    put_unk(1, 0, 1); send("R4 no hop", 1);
    put_hop(6); send("R10 b2b a", 0, 0);
    put_pv(2, 0); send("R10 b2b b", 0, 0);
    put_hop(9); put_pv(3, -1); send("R10 b2b c", 1, 1);

    repeat (5) @(negedge clk);
    chk("R10", "pending decisions", 32'(exp_q.size()), 32'(0));
    finish_run();
  end
endmodule